// File: doc/BRIEF.md
# I2C Bus Master with Register-Started Transfers

This block is a single-master I2C engine that a host controls through five byte-wide registers. The host sets a clock divisor and enables the block. It then writes a slave address with the direction bit into the address register. That one write starts the transfer. The engine picks START or repeated START from the tracked bus state. If a read acknowledge is still owed, the engine sends it first. The write also clears every flag.

Address and data bytes are shifted MSB first, and the slave's acknowledge is sampled. Between operations the engine keeps SCL low until the host gives the next command. Writing the data register sends a byte. A control-register command returns ACK or NACK for a received byte and then either reads on or ends with STOP.

The engine watches the lines when it is not driving them, so it knows whether the bus is idle or busy. It also detects arbitration loss while it sends. The pad outputs are active-low requests: 0 pulls the line low and 1 releases it.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, both line outputs are 1 (released), and the control, status, divisor, address and data registers all read 0. Bus state 00 means unknown.
- R2: SCL high time and SCL low time during a bit are each 5 + DIV system clocks, where DIV is the divisor register at select 2.
- R3: Writes to the divisor register are ignored while the enable bit (control bit 0) is 1.
- R4: Writing the address register (select 3) while the bus is idle produces a START and shifts the 8 written bits MSB first, with the direction bit last. After the slave's ninth bit, the write flag (status bit 6) is set, status bit 4 holds the sampled acknowledge (1 = NACK), and SCL stays low. When the address was a write, writing the data register (select 4) then sends that byte the same way.
- R5: Writing the address register while this master owns the bus (status bits 1:0 = 10) produces a repeated START without a STOP.
- R6: If a received byte has not yet been acknowledged, an address write first sends the acknowledge bit with the level held in control bit 1, and only then the repeated START.
- R7: Writing the address register while the bus state is unknown causes no line activity and sets both the write flag and the bus-error flag (status bit 2).
- R8: Any accepted address write clears the read flag (bit 7), the write flag (bit 6), the NACK bit (bit 4), the arbitration flag (bit 3) and the bus-error flag (bit 2).
- R9: The address register reads back the written value at any time, including during a transfer.
- R10: A data-register write made while a byte is being shifted is ignored.
- R11: If SDA reads low at the end of an SCL high phase while the engine releases it during an address or data bit, the arbitration flag is set, both lines are released and the bus state becomes busy (11).
- R12: After a read address is acknowledged, the engine receives a byte into the data register, sets the read flag (bit 7) and holds SCL low. A control write with command bits 3:2 = 01 sends the acknowledge bit and reads the next byte; with 10 it sends the acknowledge bit if one is owed and then a STOP. Either command clears bits 7 and 6.
- R13: When not owning the bus, a START seen on the lines sets the state to busy (11) and a STOP sets it to idle (01). A status write of 01 in bits 1:0 also forces the state to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 status, 2 divisor, 3 address, 4 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| scl_o | output | 1 | SCL request, 0 pulls low |
| scl_i | input | 1 | Sensed SCL level |
| sda_o | output | 1 | SDA request, 0 pulls low |
| sda_i | input | 1 | Sensed SDA level |

## Verification
The overlap that matters most is an address write that finds a read acknowledge still owed. One register write then has to perform two functions back to back: send the acknowledge bit and start the repeated START. The bench reads a byte, sets control bit 1 to NACK, and writes the address. The scoreboard must see the acknowledge event with level 1 strictly before the next START event and the new address byte. A second coincidence comes from the arbitration case: an external pull-down turns the engine's own transfer into a bus-busy state. Releasing that pull-down then looks like a STOP, so the bench expects the tracker to go from busy to idle on the same line edge.

// File: rtl/i2c_reg_master.sv
module i2c_reg_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_o,
  input  logic       scl_i,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam logic [1:0] BUS_UNK = 2'b00, BUS_IDLE = 2'b01, BUS_OWN = 2'b10, BUS_BUSY = 2'b11;
  localparam logic [1:0] OP_ADDR = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_ACK = 2'd3;
  localparam logic [1:0] NX_READ = 2'd0, NX_STOP = 2'd1, NX_RS = 2'd2;

  typedef enum logic [3:0] {S_IDLE, S_START, S_RS_LO, S_RS_HI, S_LO, S_HI,
                            S_STOP_LO, S_STOP_HI, S_STOP_END} st_t;
  st_t st;

  logic       en_q, ack_act_q, rif_q, wif_q, arb_q, berr_q, rxnack_q;
  logic       ack_pend, start_wait, scl_q, sda_q;
  logic [1:0] bus_q, op_q, nxt_q;
  logic [7:0] baud_q, addr_q, data_q, rx;
  logic [8:0] sh, cnt;
  logic [3:0] nb;

  wire [8:0] half   = 9'd5 + {1'b0, baud_q};
  wire       hi_st  = st == S_HI || st == S_RS_HI || st == S_STOP_HI || st == S_START || st == S_STOP_END;
  wire       adv    = st != S_IDLE && !(hi_st && !scl_i);
  wire       step   = adv && cnt == half - 9'd1;
  wire       idle_e = st == S_IDLE;
  wire       wr_ctl = reg_we && reg_sel == 3'd0;
  wire       wr_sts = reg_we && reg_sel == 3'd1;
  wire       wr_bd  = reg_we && reg_sel == 3'd2;
  wire       wr_adr = reg_we && reg_sel == 3'd3;
  wire       wr_dat = reg_we && reg_sel == 3'd4;
  wire       start_det = scl_q && scl_i && sda_q && !sda_i;
  wire       stop_det  = scl_q && scl_i && !sda_q && sda_i;
  wire       arb_chk   = (op_q == OP_ADDR || op_q == OP_WR) && nb != 4'd1;

  assign scl_o = !(st == S_LO || st == S_RS_LO || st == S_STOP_LO || (idle_e && bus_q == BUS_OWN));

  always_comb begin
    case (st)
      S_START, S_STOP_LO, S_STOP_HI: sda_o = 1'b0;
      S_LO, S_HI:                    sda_o = sh[8];
      default:                       sda_o = 1'b1;
    endcase
  end

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = {6'd0, ack_act_q, en_q};
      3'd1:    reg_rdata = {rif_q, wif_q, 1'b0, rxnack_q, arb_q, berr_q, bus_q};
      3'd2:    reg_rdata = baud_q;
      3'd3:    reg_rdata = addr_q;
      3'd4:    reg_rdata = data_q;
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bus_q <= BUS_UNK; op_q <= OP_ADDR; nxt_q <= NX_READ;
      en_q <= 1'b0; ack_act_q <= 1'b0; rif_q <= 1'b0; wif_q <= 1'b0; arb_q <= 1'b0;
      berr_q <= 1'b0; rxnack_q <= 1'b0; ack_pend <= 1'b0; start_wait <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1; baud_q <= '0; addr_q <= '0; data_q <= '0;
      rx <= '0; sh <= '1; cnt <= '0; nb <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      cnt   <= (!adv || step) ? 9'd0 : cnt + 9'd1;

      if (wr_bd && !en_q) baud_q <= reg_wdata;

      if (en_q && bus_q != BUS_OWN) begin
        if (start_det) bus_q <= BUS_BUSY;
        else if (stop_det) bus_q <= BUS_IDLE;
      end
      if (wr_sts && en_q && bus_q != BUS_OWN && reg_wdata[1:0] == BUS_IDLE) bus_q <= BUS_IDLE;

      if (wr_dat && idle_e) begin
        data_q <= reg_wdata;
        if (en_q && bus_q == BUS_OWN && !ack_pend) begin
          rif_q <= 1'b0; wif_q <= 1'b0;
          sh <= {reg_wdata, 1'b1}; nb <= 4'd9; op_q <= OP_WR; st <= S_LO;
        end
      end

      if (wr_adr && en_q && idle_e) begin
        addr_q <= reg_wdata;
        rif_q <= 1'b0; wif_q <= 1'b0; arb_q <= 1'b0; berr_q <= 1'b0; rxnack_q <= 1'b0;
        case (bus_q)
          BUS_UNK:  begin wif_q <= 1'b1; berr_q <= 1'b1; end
          BUS_IDLE: begin st <= S_START; bus_q <= BUS_OWN; end
          BUS_OWN:  if (ack_pend) begin
                      sh <= {ack_act_q, 8'hFF}; nb <= 4'd1; op_q <= OP_ACK; nxt_q <= NX_RS;
                      ack_pend <= 1'b0; st <= S_LO;
                    end else st <= S_RS_LO;
          default:  start_wait <= 1'b1;
        endcase
      end

      if (start_wait && idle_e && bus_q == BUS_IDLE) begin
        start_wait <= 1'b0; st <= S_START; bus_q <= BUS_OWN;
      end

      if (step) begin
        case (st)
          S_START:    begin sh <= {addr_q, 1'b1}; nb <= 4'd9; op_q <= OP_ADDR; st <= S_LO; end
          S_RS_LO:    st <= S_RS_HI;
          S_RS_HI:    st <= S_START;
          S_LO:       st <= S_HI;
          S_STOP_LO:  st <= S_STOP_HI;
          S_STOP_HI:  st <= S_STOP_END;
          S_STOP_END: begin st <= S_IDLE; bus_q <= BUS_IDLE; end
          S_HI: begin
            rx <= {rx[6:0], sda_i};
            if (arb_chk && sh[8] && !sda_i) begin
              arb_q <= 1'b1; bus_q <= BUS_BUSY; st <= S_IDLE;
            end else if (nb != 4'd1) begin
              sh <= {sh[7:0], 1'b1}; nb <= nb - 4'd1; st <= S_LO;
            end else begin
              case (op_q)
                OP_ADDR: begin
                  rxnack_q <= sda_i;
                  if (addr_q[0] && !sda_i) begin
                    sh <= '1; nb <= 4'd8; op_q <= OP_RD; st <= S_LO;
                  end else begin wif_q <= 1'b1; st <= S_IDLE; end
                end
                OP_WR:   begin rxnack_q <= sda_i; wif_q <= 1'b1; st <= S_IDLE; end
                OP_RD:   begin data_q <= {rx[6:0], sda_i}; rif_q <= 1'b1; ack_pend <= 1'b1; st <= S_IDLE; end
                default: begin
                  case (nxt_q)
                    NX_READ: begin sh <= '1; nb <= 4'd8; op_q <= OP_RD; st <= S_LO; end
                    NX_STOP: st <= S_STOP_LO;
                    default: st <= S_RS_LO;
                  endcase
                end
              endcase
            end
          end
          default: st <= S_IDLE;
        endcase
      end

      if (wr_ctl) begin
        en_q <= reg_wdata[0];
        ack_act_q <= reg_wdata[1];
        if (!reg_wdata[0]) begin
          st <= S_IDLE; bus_q <= BUS_UNK; ack_pend <= 1'b0; start_wait <= 1'b0;
        end else if (en_q && idle_e && bus_q == BUS_OWN && reg_wdata[3:2] != 2'b00) begin
          rif_q <= 1'b0; wif_q <= 1'b0;
          if (ack_pend) begin
            sh <= {reg_wdata[1], 8'hFF}; nb <= 4'd1; op_q <= OP_ACK; ack_pend <= 1'b0; st <= S_LO;
            nxt_q <= (reg_wdata[3:2] == 2'b01) ? NX_READ : NX_STOP;
          end else if (reg_wdata[3:2] == 2'b10) st <= S_STOP_LO;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_sel,
  input logic       en,
  input logic [3:0] st,
  input logic [1:0] bus,
  input logic [1:0] op,
  input logic       rif,
  input logic       wif,
  input logic       arb,
  input logic       berr,
  input logic [7:0] baud,
  input logic [7:0] addr,
  input logic [7:0] data,
  input logic       scl_o,
  input logic       sda_o
);
  wire adr_go = reg_we && reg_sel == 3'd3 && en && st == 4'd0;

  a_r8_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_go && bus != 2'b00) |=> (!rif && !wif && !arb && !berr));

  a_r7_unknown_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_go && bus == 2'b00) |=> (wif && berr && scl_o && sda_o));

  a_r3_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(baud));

  a_r9_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 4'd0) |=> $stable(addr));

  a_r10_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 4'd0 && op != 2'd2) |=> $stable(data));

  a_r11_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> (scl_o && sda_o && bus == 2'b11));

  a_r12_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rif && en) |-> !scl_o);
endmodule

bind i2c_reg_master i2c_reg_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .en(en_q), .st(st),
  .bus(bus_q), .op(op_q), .rif(rif_q), .wif(wif_q), .arb(arb_q), .berr(berr_q),
  .baud(baud_q), .addr(addr_q), .data(data_q), .scl_o(scl_o), .sda_o(sda_o));

// File: tb/i2c_reg_master_tb_top.sv
module i2c_reg_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic scl_o, sda_o;
  logic slv_sda = 1'b1, ext_sda = 1'b1;
  wire  scl_bus = scl_o;
  wire  sda_bus = sda_o & slv_sda & ext_sda;

  int checks = 0, errors = 0;
  logic mon_en = 1'b1;
  logic slv_nack = 1'b0;
  logic [9:0] exp_q[$];
  logic [7:0] slv_tx [0:3] = '{8'h96, 8'h3C, 8'h00, 8'h00};

  always #2 clk = ~clk;

  i2c_reg_master dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_o(scl_o), .scl_i(scl_bus),
    .sda_o(sda_o), .sda_i(sda_bus));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard: kind 0 START, 1 byte seen by slave, 2 STOP, 3 master acknowledge level
  task automatic expect_ev(input logic [1:0] k, input logic [7:0] v);
    exp_q.push_back({k, v});
  endtask

  task automatic observe(input logic [1:0] k, input logic [7:0] v);
    logic [9:0] e;
    if (!mon_en) return;
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R4 unexpected bus event actual=%0h expected=none", {k, v});
    end else begin
      e = exp_q.pop_front();
      check("R4/R5/R6/R12 bus event order", {k, v}, e);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic wait_status(input logic [7:0] mask, input logic [7:0] val);
    logic [7:0] v;
    for (int i = 0; i < 6000; i++) begin
      rd(3'd1, v);
      if ((v & mask) == val) return;
    end
    checks++; errors++;
    $display("FAIL wait status actual=%0h expected=%0h", v & mask, val);
  endtask

  // slave model on the opposite clock edge
  logic ps = 1'b1, pd = 1'b1, active = 1'b0, rxm = 1'b1, isa = 1'b0, rw = 1'b0, done_tx = 1'b0;
  int bc = 0, ti = 0;
  logic [7:0] sr = 8'd0, tx = 8'd0;
  always @(negedge clk) begin
    logic s, d;
    s = scl_bus; d = sda_bus;
    if (ps && s && pd && !d) begin
      active = 1'b1; bc = 0; rxm = 1'b1; isa = 1'b1; done_tx = 1'b0; slv_sda = 1'b1;
      observe(2'd0, 8'd0);
    end else if (ps && s && !pd && d) begin
      if (active) observe(2'd2, 8'd0);
      active = 1'b0; slv_sda = 1'b1;
    end else if (active && s && !ps) begin
      if (bc < 8) begin
        if (rxm) sr = {sr[6:0], d};
      end else if (bc == 8 && !rxm) begin
        observe(2'd3, {7'd0, d});
        if (d) done_tx = 1'b1;
      end
      bc++;
    end else if (active && !s && ps) begin
      if (bc == 8 && rxm) begin
        observe(2'd1, sr);
        slv_sda = slv_nack;
        if (isa) rw = sr[0];
      end else if (bc == 8) slv_sda = 1'b1;
      else if (bc == 9) begin
        bc = 0; slv_sda = 1'b1;
        if ((isa && rw && !slv_nack) || (!isa && !rxm && !done_tx)) begin
          rxm = 1'b0; tx = slv_tx[ti]; ti++; slv_sda = tx[7];
        end
        isa = 1'b0;
      end else if (!rxm && bc > 0) slv_sda = tx[7-bc];
    end
    ps = s; pd = d;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    #9 rst_n = 1'b1;
    // R1 reset state
    rd(3'd1, v); check("R1 status", v, 8'h00);
    rd(3'd2, v); check("R1 divisor", v, 8'h00);
    rd(3'd0, v); check("R1 control", v, 8'h00);
    check("R1 lines released", {scl_o, sda_o}, 2'b11);

    wr(3'd2, 8'd3);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h20);
    rd(3'd2, v); check("R3 divisor ignored while enabled", v, 8'd3);

    // R7 unknown bus
    wr(3'd3, 8'hA0);
    rd(3'd1, v); check("R7 error flags", v, 8'h44);
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!scl_bus || !sda_bus) n++; end
    check("R7 no line activity", n, 0);

    wr(3'd1, 8'h01);
    rd(3'd1, v); check("R13 forced idle", v, 8'h45);

    // R4 address write, R8 clear, R9 readback, R10 blocked data, R2 timing
    expect_ev(2'd0, 8'd0); expect_ev(2'd1, 8'hA0);
    wr(3'd3, 8'hA0);
    rd(3'd1, v); check("R8 flags cleared", v, 8'h02);
    rd(3'd3, v); check("R9 address readback in flight", v, 8'hA0);
    wr(3'd4, 8'h77);
    while (scl_bus) @(negedge clk);
    while (!scl_bus) @(negedge clk);
    n = 0;
    while (scl_bus) begin n++; @(negedge clk); end
    check("R2 SCL high clocks", n, 8);
    n = 0;
    while (!scl_bus) begin n++; @(negedge clk); end
    check("R2 SCL low clocks", n, 8);
    wait_status(8'h40, 8'h40);
    rd(3'd1, v); check("R4 write flag after address", v, 8'h42);
    rd(3'd4, v); check("R10 data write during shift ignored", v, 8'h00);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (scl_bus) n++; end
    check("R4 SCL held low", n, 0);

    // data bytes
    expect_ev(2'd1, 8'h5A);
    wr(3'd4, 8'h5A);
    wait_status(8'h40, 8'h40);
    rd(3'd1, v); check("R4 data byte acked", v, 8'h42);
    slv_nack = 1'b1;
    expect_ev(2'd1, 8'hC3);
    wr(3'd4, 8'hC3);
    wait_status(8'h40, 8'h40);
    rd(3'd1, v); check("R4 data byte nacked", v, 8'h52);
    slv_nack = 1'b0;

    // R5 repeated start into a read, R12 receive
    expect_ev(2'd0, 8'd0); expect_ev(2'd1, 8'hA1);
    wr(3'd3, 8'hA1);
    wait_status(8'h80, 8'h80);
    rd(3'd1, v); check("R12 read flag", v, 8'h82);
    rd(3'd4, v); check("R12 first byte", v, 8'h96);
    expect_ev(2'd3, 8'd0);
    wr(3'd0, 8'h05);
    wait_status(8'h80, 8'h80);
    rd(3'd4, v); check("R12 second byte", v, 8'h3C);

    // R6 owed NACK goes out before the repeated START
    wr(3'd0, 8'h03);
    expect_ev(2'd3, 8'd1); expect_ev(2'd0, 8'd0); expect_ev(2'd1, 8'hA0);
    wr(3'd3, 8'hA0);
    wait_status(8'h40, 8'h40);
    rd(3'd1, v); check("R6 write flag after chained restart", v, 8'h42);

    expect_ev(2'd2, 8'd0);
    wr(3'd0, 8'h09);
    wait_status(8'h03, 8'h01);
    rd(3'd1, v); check("R12 stop clears flags", v, 8'h01);
    check("R12 lines released after stop", {scl_o, sda_o}, 2'b11);

    // R11 arbitration loss, R13 tracker
    mon_en = 1'b0;
    wr(3'd3, 8'hA0);
    while (scl_bus) @(negedge clk);
    ext_sda = 1'b0;
    wait_status(8'h08, 8'h08);
    rd(3'd1, v); check("R11 arbitration lost, bus busy", v, 8'h0B);
    check("R11 lines released", {scl_o, sda_o}, 2'b11);
    @(negedge clk); ext_sda = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd1, v); check("R13 external STOP gives idle", v, 8'h09);
    ext_sda = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd1, v); check("R13 external START gives busy", v, 8'h0B);
    ext_sda = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd1, v); check("R13 external STOP again", v, 8'h09);
    mon_en = 1'b1;

    expect_ev(2'd0, 8'd0); expect_ev(2'd1, 8'h42);
    wr(3'd3, 8'h42);
    rd(3'd1, v); check("R8 arbitration flag cleared", v, 8'h02);
    wait_status(8'h40, 8'h40);
    expect_ev(2'd2, 8'd0);
    wr(3'd0, 8'h09);
    wait_status(8'h03, 8'h01);
    repeat (5) @(negedge clk);
    check("R4 all expected bus events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule